// File: doc/BRIEF.md
# Configurable Output Pin Router

This block drives a small set of general-purpose output pins, four by default. Each pin has its own select field that picks one internal signal out of a fixed set: a clock output, a receiver-running indicator, an interrupt line, a constant low, a constant high, two data streams (raw and matched-filter), channel data with its strobe, and received data with its strobe. After selection, each pin can be inverted on its own.

The running indicator is gated per pin and per receiver configuration. A flat enable vector holds one bit for each pin in each configuration, and a configuration index picks which row applies. The routed values are registered so that the pins do not glitch when a select field or a source changes. The clock output is the exception: it takes a combinational path so that it keeps its own timing. The last pin cannot carry the clock. A power-on input disables every output driver when it is low. The register bus and the pad cells sit outside this block. The select, inversion and enable fields arrive here as plain inputs.

Top module: `pin_router`

## Requirements
- R1: While reset is asserted and no pin selects the clock, every pin value is 0.
- R2: Each pin's select field is `pin_sel[4*p+3:4*p]`. The codes are 1 run indicator, 2 interrupt, 3 constant low, 4 constant high, 5 data, 6 matched-filter data, 7 channel data, 8 channel strobe, 9 received data and 10 received strobe. For these codes the pin shows the selected source one clock edge after the select or the source changes, and not before that edge.
- R3: Select codes 11 to 15 act as a constant low source.
- R4: When `pin_inv[p]` is 1, pin p shows the complement of its selected source.
- R5: Code 0 routes `src_clk` to pins 0 to 2 with no register on the path, and inversion still applies.
- R6: Code 0 on the last pin (pin 3) acts as a constant low source. Inversion still applies, so an inverted pin shows 1.
- R7: A pin that selects the run indicator shows 0 before inversion when its enable bit `run_en[4*cfg_idx+p]` is 0, even if `src_run` is 1.
- R8: The enable row in use is the one picked by `cfg_idx`. The bits of the other configurations have no effect.
- R9: While `pwr_on` is 0, every `pin_oe` bit is 0 and every `pin_out` bit is 0, with no clock edge needed.
- R10: While `pwr_on` is 1, every `pin_oe` bit is 1, and this holds during reset as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power-on level; low floats all pins |
| src_clk | input | 1 | Clock output source |
| src_run | input | 1 | Receiver running indicator, active high |
| src_irq | input | 1 | Interrupt source |
| src_data | input | 1 | Data stream |
| src_mfd | input | 1 | Matched-filter data |
| src_chd | input | 1 | Channel data |
| src_chs | input | 1 | Channel strobe |
| src_rxd | input | 1 | Received data |
| src_rxs | input | 1 | Received strobe |
| pin_sel | input | 16 | Per-pin 4-bit source select, pin p at bits 4p+3..4p |
| pin_inv | input | 4 | Per-pin inversion |
| run_en | input | 16 | Run indicator enables, bit 4*cfg+pin |
| cfg_idx | input | 2 | Active receiver configuration |
| pin_out | output | 4 | Pin values toward the pads |
| pin_oe | output | 4 | Pin output enables |

## Verification
The bench uses the default parameters: four pins and four configurations. With these values the clock restriction falls on pin 3, and enable rows 1 and 2 can be set to different patterns so that the selection made by the configuration index shows at the pins. Table vectors hold `src_clk` high throughout. A last pin that wrongly passed the clock, or that applied no inversion to its low level, would therefore show up at once. Directed steps cover the register latency of the routed path, the unregistered clock path, and the power-off float.

// File: rtl/pin_router_pkg.sv
package pin_router_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_CLK  = 4'd0,
        SRC_RUN  = 4'd1,
        SRC_IRQ  = 4'd2,
        SRC_LOW  = 4'd3,
        SRC_HIGH = 4'd4,
        SRC_DATA = 4'd5,
        SRC_MFD  = 4'd6,
        SRC_CHD  = 4'd7,
        SRC_CHS  = 4'd8,
        SRC_RXD  = 4'd9,
        SRC_RXS  = 4'd10
    } src_code_e;

    // first code with no source behind it; it and all above read low
    localparam logic [SEL_W-1:0] FIRST_UNUSED = 4'd11;

    typedef struct packed {
        logic run;
        logic irq;
        logic data;
        logic mfd;
        logic chd;
        logic chs;
        logic rxd;
        logic rxs;
    } sig_bundle_t;

endpackage

// File: rtl/pin_src_mux.sv
module pin_src_mux
    import pin_router_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    input  sig_bundle_t      sigs,
    output logic             raw
);

    always_comb begin
        case (code)
            SRC_RUN:  raw = sigs.run;
            SRC_IRQ:  raw = sigs.irq;
            SRC_LOW:  raw = 1'b0;
            SRC_HIGH: raw = 1'b1;
            SRC_DATA: raw = sigs.data;
            SRC_MFD:  raw = sigs.mfd;
            SRC_CHD:  raw = sigs.chd;
            SRC_CHS:  raw = sigs.chs;
            SRC_RXD:  raw = sigs.rxd;
            SRC_RXS:  raw = sigs.rxs;
            // clock goes through the bypass; unused codes read low
            default:  raw = 1'b0;
        endcase
    end

endmodule

// File: rtl/pin_lane.sv
module pin_lane
    import pin_router_pkg::*;
#(
    parameter bit ALLOW_CLK = 1'b1
) (
    input  logic [SEL_W-1:0] code,
    input  sig_bundle_t      sigs,
    input  logic             run_ok,
    input  logic             inv,
    output logic             nxt,
    output logic             clk_route
);

    sig_bundle_t masked;
    logic [SEL_W-1:0] code_eff;
    logic raw;

    always_comb begin
        masked     = sigs;
        masked.run = sigs.run & run_ok;
    end

    generate
        if (ALLOW_CLK) begin : g_clk_ok
            assign code_eff  = code;
            assign clk_route = (code == SRC_CLK);
        end else begin : g_clk_blocked
            // clock code on this pin is demoted to a constant low source
            assign code_eff  = (code == SRC_CLK) ? SRC_LOW : code;
            assign clk_route = 1'b0;
        end
    endgenerate

    pin_src_mux u_mux (
        .code (code_eff),
        .sigs (masked),
        .raw  (raw)
    );

    assign nxt = raw ^ inv;

endmodule

// File: rtl/pin_router.sv
module pin_router
    import pin_router_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int NUM_CFGS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pwr_on,
    input  logic                         src_clk,
    input  logic                         src_run,
    input  logic                         src_irq,
    input  logic                         src_data,
    input  logic                         src_mfd,
    input  logic                         src_chd,
    input  logic                         src_chs,
    input  logic                         src_rxd,
    input  logic                         src_rxs,
    input  logic [NUM_PINS*SEL_W-1:0]    pin_sel,
    input  logic [NUM_PINS-1:0]          pin_inv,
    input  logic [NUM_PINS*NUM_CFGS-1:0] run_en,
    input  logic [((NUM_CFGS > 1) ? $clog2(NUM_CFGS) : 1)-1:0] cfg_idx,
    output logic [NUM_PINS-1:0]          pin_out,
    output logic [NUM_PINS-1:0]          pin_oe
);

    localparam int NO_CLK_PIN = NUM_PINS - 1;

    typedef struct packed {
        logic [NUM_PINS-1:0] pin;
    } state_t;

    state_t              state_d, state_q;
    sig_bundle_t         sigs;
    logic [NUM_PINS-1:0] run_row;
    logic [NUM_PINS-1:0] lane_nxt;
    logic [NUM_PINS-1:0] clk_route;

    always_comb begin
        sigs.run  = src_run;
        sigs.irq  = src_irq;
        sigs.data = src_data;
        sigs.mfd  = src_mfd;
        sigs.chd  = src_chd;
        sigs.chs  = src_chs;
        sigs.rxd  = src_rxd;
        sigs.rxs  = src_rxs;
    end

    // enable row of the active configuration
    always_comb begin
        run_row = run_en[int'(cfg_idx)*NUM_PINS +: NUM_PINS];
    end

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_lane
            pin_lane #(
                .ALLOW_CLK (g != NO_CLK_PIN)
            ) u_lane (
                .code      (pin_sel[g*SEL_W +: SEL_W]),
                .sigs      (sigs),
                .run_ok    (run_row[g]),
                .inv       (pin_inv[g]),
                .nxt       (lane_nxt[g]),
                .clk_route (clk_route[g])
            );
        end
    endgenerate

    always_comb begin
        state_d     = state_q;
        state_d.pin = lane_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // clock bypass and power gating
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            pin_out[i] = pwr_on & (clk_route[i] ? (src_clk ^ pin_inv[i])
                                                : state_q.pin[i]);
        end
        pin_oe = {NUM_PINS{pwr_on}};
    end

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
            p_reg_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && pwr_on && !clk_route[g])
                    |-> pin_out[g] == $past(lane_nxt[g]));

            p_unused_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_sel[g*SEL_W +: SEL_W] >= FIRST_UNUSED)
                    |-> lane_nxt[g] == pin_inv[g]);

            p_run_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_sel[g*SEL_W +: SEL_W] == SRC_RUN
                    && !run_en[int'(cfg_idx)*NUM_PINS + g])
                    |-> lane_nxt[g] == pin_inv[g]);
        end
    endgenerate

    p_last_no_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pwr_on
            && pin_sel[NO_CLK_PIN*SEL_W +: SEL_W] == SRC_CLK
            && $past(pin_sel[NO_CLK_PIN*SEL_W +: SEL_W] == SRC_CLK)
            && $stable(pin_inv[NO_CLK_PIN]))
            |-> pin_out[NO_CLK_PIN] == pin_inv[NO_CLK_PIN]);

    p_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (pin_out == '0 && pin_oe == '0));

    p_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on |-> pin_oe == {NUM_PINS{1'b1}});

endmodule

// File: tb/pin_router_bench.sv
`timescale 1ns/1ps
module pin_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_on = 1'b1;
    logic        src_clk = 1'b0;
    logic        src_run = 1'b0, src_irq = 1'b0, src_data = 1'b0, src_mfd = 1'b0;
    logic        src_chd = 1'b0, src_chs = 1'b0, src_rxd = 1'b0, src_rxs = 1'b0;
    logic [15:0] pin_sel = 16'h4444;
    logic [3:0]  pin_inv = 4'h0;
    logic [15:0] run_en = 16'hFFFF;
    logic [1:0]  cfg_idx = 2'd0;
    logic [3:0]  pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pin_router u_pin_router (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .src_clk(src_clk),
        .src_run(src_run), .src_irq(src_irq), .src_data(src_data),
        .src_mfd(src_mfd), .src_chd(src_chd), .src_chs(src_chs),
        .src_rxd(src_rxd), .src_rxs(src_rxs), .pin_sel(pin_sel),
        .pin_inv(pin_inv), .run_en(run_en), .cfg_idx(cfg_idx),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {sel[16], inv[4], run_en[16], cfg[2], src{rxs,rxd,chs,chd,mfd,data,irq,run}[8], expect[4]}
    localparam int NV = 9;
    localparam logic [49:0] VEC [NV] = '{
        {16'h4321, 4'b0000, 16'hFFFF, 2'd0, 8'h01, 4'b1001},  // R2 run/irq/low/high
        {16'h8765, 4'b0000, 16'hFFFF, 2'd0, 8'h34, 4'b1101},  // R2 data/mf/chd/chs
        {16'hA9A9, 4'b0110, 16'hFFFF, 2'd0, 8'h40, 4'b0011},  // R4 rx with inversion
        {16'hFEDB, 4'b1010, 16'hFFFF, 2'd0, 8'hFF, 4'b1010},  // R3 unused codes
        {16'h1111, 4'b0000, 16'hF5FF, 2'd2, 8'h01, 4'b0101},  // R7 masked row 2
        {16'h1111, 4'b0000, 16'hF5FF, 2'd1, 8'h01, 4'b1111},  // R8 row 1 unmasked
        {16'h1111, 4'b0011, 16'hF5FF, 2'd2, 8'h01, 4'b0110},  // R7 mask then invert
        {16'h0444, 4'b0000, 16'hFFFF, 2'd0, 8'h00, 4'b0111},  // R6 clock on last pin
        {16'h0444, 4'b1000, 16'hFFFF, 2'd0, 8'h00, 4'b1111}   // R6 inverted
    };

    function automatic string tag_of(int k);
        case (k)
            0, 1:    return "R2";
            2:       return "R4";
            3:       return "R3";
            4, 6:    return "R7";
            5:       return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 / R10 during reset
        #12;
        check("R1", pin_out, 4'b0000);
        check("R10", pin_oe, 4'b1111);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        src_clk = 1'b1;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            pin_sel = VEC[k][49:34];
            pin_inv = VEC[k][33:30];
            run_en  = VEC[k][29:14];
            cfg_idx = VEC[k][13:12];
            {src_rxs, src_rxd, src_chs, src_chd, src_mfd, src_data, src_irq, src_run} = VEC[k][11:4];
            @(posedge clk);
            #1;
            check(tag_of(k), pin_out, VEC[k][3:0]);
        end

        // R2 latency: change holds until the next edge
        @(negedge clk);
        pin_sel = 16'h3333;
        pin_inv = 4'h0;
        @(posedge clk);
        #1;
        check("R2", pin_out, 4'b0000);
        @(negedge clk);
        pin_sel = 16'h4444;
        #1;
        check("R2", pin_out, 4'b0000);
        @(posedge clk);
        #1;
        check("R2", pin_out, 4'b1111);

        // R5 combinational clock path on pins 0 and 1
        @(negedge clk);
        pin_sel = 16'h4400;
        pin_inv = 4'b0010;
        src_clk = 1'b0;
        @(posedge clk);
        #1;
        check("R5", pin_out, 4'b1110);
        src_clk = 1'b1;
        #1;
        check("R5", pin_out, 4'b1101);

        // R9 power off floats everything at once
        pwr_on = 1'b0;
        #1;
        check("R9", pin_out, 4'b0000);
        check("R9", pin_oe, 4'b0000);
        @(posedge clk);
        #1;
        check("R9", pin_out, 4'b0000);

        // R10 power back on
        pwr_on = 1'b1;
        #1;
        check("R10", pin_oe, 4'b1111);
        check("R10", pin_out, 4'b1101);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule